// File: doc/BRIEF.md
# Colour-Sequenced PWM Event Table Builder

This block turns sixteen 8-bit duty levels for one colour plane into an ordered event table that a PWM timer walks during one colour period. Each table entry holds a 16-bit output mask, the timer value at which the next event fires, and a flag that tells the timer whether another event follows. The builder works out the order in which channels switch off. Channels with equal duty switch off in the same event. Channels at full scale stay on for the whole period. Channels at zero never switch on.

The table memory is shared with the display logic. For that reason, an entry for a colour plane is written only while the plane that comes before it in the red → green → blue rotation is on display. The engine runs sequentially. A single comparator visits one channel per cycle, and one pass over all channels produces one event. A start pulse latches the duty levels and the target plane. The engine then raises busy and writes the 17 entries of that plane in ascending order. It ends with a one-cycle done pulse.

Top module: `ptb_builder`

## Requirements
- R1: Each write carries address `plane*17 + entry` (plane 0 red, 1 green, 2 blue; entry 0..16). Its data word has the mask of channels 0..7 in bits [7:0], the mask of channels 8..15 in bits [15:8], the compare value in bits [23:16], the continue flag in bit 24, and zeros in bits [31:25].
- R2: The mask of entry 0 has a bit set for exactly those channels whose latched duty is above zero.
- R3: Take the smallest latched duty among channels that are still on in the previous mask and below 0xFF. Entry k+1 clears every channel with that duty at once, and entry k carries that duty as its compare value with the flag set to 1.
- R4: A channel whose duty is 0xFF stays set in every mask from entry 0 through entry 16.
- R5: A channel whose duty is zero is clear in every mask and produces no event of its own.
- R6: Once no candidate is left, that entry and every later entry repeat the last mask with compare 0 and flag 0. Entry 16 always has flag 0.
- R7: Red entries are written only while the display plane input is 1 (green). Green entries are written only while it is 2 (blue), and blue entries only while it is 0 (red). In any other cycle the engine holds the pending entry, and no entry is lost or repeated.
- R8: A start pulse while idle with plane 0..2 raises busy on the next cycle. Plane 3 is ignored. A start while busy or while done is high is ignored. Done is high for exactly one cycle after entry 16 is written, and busy is low while done is high.
- R9: A build writes exactly 17 entries, each once, in ascending entry order.
- R10: Duty levels are latched in the start cycle. Changes to the duty input during a build do not alter the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to build the table for `colour_sel` |
| colour_sel | input | 2 | Target plane: 0 red, 1 green, 2 blue, 3 none |
| duty_flat | input | 128 | Duty of channel i in bits [8i+7:8i] |
| disp_colour | input | 2 | Plane currently on display: 0 red, 1 green, 2 blue, 3 blank |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle pulse at the end of a build |
| wr_en | output | 1 | Table write strobe |
| wr_addr | output | 6 | Table word address, `plane*17 + entry` |
| wr_data | output | 32 | Table entry word |

## Verification
The bench covers several corner cases, and each one points to a specific fault:
- **All channels at 0xFF.** A builder that lets full-scale channels take part in the minimum search would create a spurious event.
- **All channels at zero.** A builder that starts from an all-ones mask would emit a zero-compare event.
- **All sixteen duties equal.** A builder that clears one channel per pass instead of every channel at the minimum would spread them over many entries.
- **Sixteen distinct duties.** This fills every entry. A builder that stops one pass early, or that sets the flag on entry 16, would leave the last event wrong or non-terminated.
- **Fence tests.** Starting under the wrong display plane, and toggling the display during a build, expose a design that writes unfenced or that skips the stalled entry.
- **Duty changes mid-build.** A design that reads the live inputs instead of latching them changes its output.
- **Start pulses in the wrong state.** Starts while busy or with plane 3 expose a design that restarts when it should not.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  localparam int PTB_CH      = 16;
  localparam int PTB_DW      = 8;
  localparam int PTB_ENTRIES = PTB_CH + 1;
  localparam int PTB_PLANES  = 3;
  localparam int PTB_AW      = $clog2(PTB_PLANES * PTB_ENTRIES);
  localparam int PTB_WW      = 32;
  localparam int PTB_RSVD    = PTB_WW - 1 - PTB_DW - PTB_CH;
  localparam int PTB_IDX_W   = $clog2(PTB_CH);
  localparam int PTB_ENT_W   = $clog2(PTB_ENTRIES);

  typedef logic [1:0] colour_t;
  localparam colour_t COL_RED   = 2'd0;
  localparam colour_t COL_GREEN = 2'd1;
  localparam colour_t COL_BLUE  = 2'd2;
  localparam colour_t COL_NONE  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } ptb_state_t;

  typedef struct packed {
    logic [PTB_RSVD-1:0] rsvd;
    logic                flag;
    logic [PTB_DW-1:0]   cmp;
    logic [PTB_CH-1:0]   mask;
  } entry_t;

  // Plane that must be on display while the given plane is rewritten.
  function automatic colour_t feeder_colour(input colour_t c);
    case (c)
      COL_RED:   return COL_GREEN;
      COL_GREEN: return COL_BLUE;
      COL_BLUE:  return COL_RED;
      default:   return COL_NONE;
    endcase
  endfunction

  function automatic logic [PTB_AW-1:0] table_addr(input colour_t c,
                                                   input logic [PTB_ENT_W-1:0] e);
    return PTB_AW'(int'(c) * PTB_ENTRIES + int'(e));
  endfunction

  function automatic logic [PTB_DW-1:0] duty_at(input logic [PTB_CH*PTB_DW-1:0] flat,
                                                input int i);
    return flat[i*PTB_DW +: PTB_DW];
  endfunction

  // Channels whose duty equals val.
  function automatic logic [PTB_CH-1:0] match_mask(input logic [PTB_CH*PTB_DW-1:0] flat,
                                                   input logic [PTB_DW-1:0] val);
    logic [PTB_CH-1:0] m;
    for (int i = 0; i < PTB_CH; i++) m[i] = (duty_at(flat, i) == val);
    return m;
  endfunction

  // Channels that switch on at the start of a period.
  function automatic logic [PTB_CH-1:0] live_mask(input logic [PTB_CH*PTB_DW-1:0] flat);
    logic [PTB_CH-1:0] m;
    for (int i = 0; i < PTB_CH; i++) m[i] = (duty_at(flat, i) != '0);
    return m;
  endfunction

  function automatic entry_t pack_entry(input logic [PTB_CH-1:0] mask,
                                        input logic [PTB_DW-1:0] cmp,
                                        input logic flag);
    entry_t e;
    e.rsvd = '0;
    e.flag = flag;
    e.cmp  = cmp;
    e.mask = mask;
    return e;
  endfunction

endpackage

// File: rtl/ptb_chan_sel.sv
// Picks one channel of the latched duty vector and says whether it may
// still take part in the minimum search.
module ptb_chan_sel #(
  parameter int N_CH = 16,
  parameter int DW   = 8,
  parameter int IW   = $clog2(N_CH)
) (
  input  logic [N_CH*DW-1:0] duty_snap,
  input  logic [N_CH-1:0]    act_mask,
  input  logic [IW-1:0]      idx,
  output logic [DW-1:0]      value,
  output logic               eligible
);
  localparam logic [DW-1:0] FULL = '1;

  always_comb begin
    value    = duty_snap[int'(idx)*DW +: DW];
    eligible = act_mask[idx] && (value != FULL);
  end
endmodule

// File: rtl/ptb_min_scan.sv
// Running minimum over the eligible channels visited during one pass.
module ptb_min_scan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          eligible,
  input  logic [DW-1:0] value,
  output logic          found,
  output logic [DW-1:0] min_val
);
  logic take;
  assign take = step && eligible && (!found || (value < min_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found   <= 1'b0;
      min_val <= '1;
    end else if (clear) begin
      found   <= 1'b0;
      min_val <= '1;
    end else if (take) begin
      found   <= 1'b1;
      min_val <= value;
    end
  end
endmodule

// File: rtl/ptb_fence.sv
// Write permission: the target plane may be touched only while its
// predecessor in the rotation is on display.
module ptb_fence
  import ptb_pkg::*;
(
  input  colour_t tgt,
  input  colour_t disp,
  output logic    allowed
);
  colour_t need;
  always_comb begin
    need    = feeder_colour(tgt);
    allowed = (need != COL_NONE) && (disp == need);
  end
endmodule

// File: rtl/ptb_builder.sv
module ptb_builder
  import ptb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [1:0]                colour_sel,
  input  logic [PTB_CH*PTB_DW-1:0]  duty_flat,
  input  logic [1:0]                disp_colour,
  output logic                      busy,
  output logic                      done,
  output logic                      wr_en,
  output logic [PTB_AW-1:0]         wr_addr,
  output logic [PTB_WW-1:0]         wr_data
);
  localparam logic [PTB_IDX_W-1:0] LAST_IDX = PTB_IDX_W'(PTB_CH - 1);
  localparam logic [PTB_ENT_W-1:0] LAST_ENT = PTB_ENT_W'(PTB_ENTRIES - 1);

  ptb_state_t                  state;
  logic [PTB_CH*PTB_DW-1:0]    snap;
  colour_t                     tgt;
  logic [PTB_CH-1:0]           act_mask;
  logic [PTB_CH-1:0]           prev_mask;
  logic [PTB_CH-1:0]           next_act;
  logic [PTB_ENT_W-1:0]        ent;
  logic [PTB_IDX_W-1:0]        idx;

  // Named internal events.
  logic ev_accept, ev_scan_last, ev_commit, ev_step, ev_finish;
  logic allowed, found, ch_eligible;
  logic [PTB_DW-1:0] ch_value, min_val;
  entry_t cur_entry;

  ptb_chan_sel #(.N_CH(PTB_CH), .DW(PTB_DW), .IW(PTB_IDX_W)) u_sel (
    .duty_snap (snap),
    .act_mask  (act_mask),
    .idx       (idx),
    .value     (ch_value),
    .eligible  (ch_eligible)
  );

  ptb_min_scan #(.DW(PTB_DW)) u_min (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ev_accept || ev_step),
    .step     (state == ST_SCAN),
    .eligible (ch_eligible),
    .value    (ch_value),
    .found    (found),
    .min_val  (min_val)
  );

  ptb_fence u_fence (
    .tgt     (tgt),
    .disp    (disp_colour),
    .allowed (allowed)
  );

  always_comb begin
    ev_accept    = (state == ST_IDLE) && start && (colour_sel != COL_NONE);
    ev_scan_last = (state == ST_SCAN) && (idx == LAST_IDX);
    ev_commit    = (state == ST_WRITE) && allowed;
    ev_step      = ev_commit && found && (ent != LAST_ENT);
    ev_finish    = ev_commit && (ent == LAST_ENT);
    next_act     = act_mask & ~match_mask(snap, min_val);
    cur_entry    = pack_entry(prev_mask, found ? min_val : '0, found);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      snap      <= '0;
      tgt       <= COL_NONE;
      act_mask  <= '0;
      prev_mask <= '0;
      ent       <= '0;
      idx       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ev_accept) begin
            snap      <= duty_flat;
            tgt       <= colour_sel;
            act_mask  <= live_mask(duty_flat);
            prev_mask <= live_mask(duty_flat);
            ent       <= '0;
            idx       <= '0;
            state     <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          idx <= idx + 1'b1;
          if (ev_scan_last) state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (ev_finish) begin
            state <= ST_DONE;
          end else if (ev_commit) begin
            ent <= ent + 1'b1;
            if (found) begin
              act_mask  <= next_act;
              prev_mask <= next_act;
              idx       <= '0;
              state     <= ST_SCAN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wr_en   = ev_commit;
  assign wr_addr = table_addr(tgt, ent);
  assign wr_data = cur_entry;
  assign busy    = (state == ST_SCAN) || (state == ST_WRITE);
  assign done    = (state == ST_DONE);

endmodule

// File: rtl/ptb_builder_chk.sv
module ptb_builder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  colour_sel,
  input logic [1:0]  disp_colour,
  input logic        busy,
  input logic        done,
  input logic        wr_en,
  input logic [5:0]  wr_addr,
  input logic [31:0] wr_data
);
  logic        ck_accept;
  logic [1:0]  ck_tgt;
  logic [1:0]  ck_feed;
  logic [4:0]  ck_cnt;
  logic [15:0] ck_last_mask;
  logic        ck_pad;
  logic [5:0]  ck_base;

  assign ck_accept = start && !busy && !done && (colour_sel != 2'd3);
  assign ck_base   = {4'b0, ck_tgt} * 6'd17;

  always_comb begin
    case (ck_tgt)
      2'd0:    ck_feed = 2'd1;
      2'd1:    ck_feed = 2'd2;
      2'd2:    ck_feed = 2'd0;
      default: ck_feed = 2'd3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_tgt <= 2'd3; ck_cnt <= '0; ck_last_mask <= '0; ck_pad <= 1'b0;
    end else if (ck_accept) begin
      ck_tgt <= colour_sel; ck_cnt <= '0; ck_pad <= 1'b0;
    end else if (wr_en) begin
      ck_cnt       <= ck_cnt + 1'b1;
      ck_last_mask <= wr_data[15:0];
      if (!wr_data[24]) ck_pad <= 1'b1;
    end
  end

  AST_WR_FENCED:   assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (disp_colour == ck_feed));                                   // R7
  AST_ADDR_ORDER:  assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr == ck_base + {1'b0, ck_cnt}));                      // R9
  AST_RSVD_ZERO:   assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[31:25] == 7'd0));                                   // R1
  AST_PAD_CMP:     assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[24]) |-> (wr_data[23:16] == 8'd0));                 // R6
  AST_PAD_STICKY:  assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ck_pad) |-> (!wr_data[24] && wr_data[15:0] == ck_last_mask)); // R6
  AST_LAST_FLAG:   assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ck_cnt == 5'd16) |-> !wr_data[24]);                          // R6
  AST_MASK_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ck_cnt != 5'd0) |-> ((wr_data[15:0] & ~ck_last_mask) == 16'd0)); // R3
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                       // R8
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                       // R8
  AST_DONE_COUNT:  assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ck_cnt == 5'd17));                                           // R9
  AST_START_BUSY:  assert property (@(posedge clk) disable iff (!rst_n)
    ck_accept |=> busy);                                                   // R8
endmodule

bind ptb_builder ptb_builder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .colour_sel(colour_sel),
  .disp_colour(disp_colour), .busy(busy), .done(done), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/ptb_builder_tb.sv
module ptb_builder_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   colour_sel = 2'd0;
  logic [127:0] duty_flat = '0;
  logic [1:0]   disp_colour = 2'd3;
  logic         busy, done, wr_en;
  logic [5:0]   wr_addr;
  logic [31:0]  wr_data;

  int checks = 0;
  int errors = 0;

  ptb_builder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .colour_sel(colour_sel),
    .duty_flat(duty_flat), .disp_colour(disp_colour), .busy(busy),
    .done(done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2.5 clk = ~clk;

  // Write monitor: sole writer of the captured table and counters.
  logic [31:0] mem [0:50];
  int wr_total = 0;
  int fence_bad = 0;
  int order_bad = 0;
  int last_addr = -1;

  function automatic logic [1:0] need_disp(input int plane);
    return (plane == 0) ? 2'd1 : (plane == 1) ? 2'd2 : 2'd0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (int'(wr_addr) <= 50) mem[wr_addr] = wr_data;
      wr_total = wr_total + 1;
      if (disp_colour != need_disp(int'(wr_addr) / 17)) fence_bad = fence_bad + 1;
      if ((int'(wr_addr) % 17) != 0 && int'(wr_addr) != last_addr + 1) order_bad = order_bad + 1;
      last_addr = int'(wr_addr);
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Reference: sorted distinct in-range duties define the event thresholds.
  function automatic logic [31:0] model_entry(input logic [127:0] f, input int k);
    int d [16];
    int m = 0;
    int thr;
    logic [15:0] msk;
    logic [31:0] w;
    for (int v = 1; v < 255; v++) begin
      logic hit = 1'b0;
      for (int c = 0; c < 16; c++) if (int'(f[c*8 +: 8]) == v) hit = 1'b1;
      if (hit) begin d[m] = v; m++; end
    end
    if (k == 0) thr = 0;
    else if (k <= m) thr = d[k-1];
    else thr = (m == 0) ? 0 : d[m-1];
    for (int c = 0; c < 16; c++) msk[c] = int'(f[c*8 +: 8]) > thr;
    w = {16'd0, msk};
    if (k < m) begin w[23:16] = 8'(d[k]); w[24] = 1'b1; end
    return w;
  endfunction

  task automatic compare_plane(input logic [127:0] f, input int plane, input string req);
    for (int k = 0; k < 17; k++) begin
      logic [31:0] e = model_entry(f, k);
      chk(mem[plane*17 + k] == e, req, mem[plane*17 + k], e);
    end
  endtask

  task automatic pulse_start(input int plane);
    @(posedge clk); #1;
    colour_sel = 2'(plane);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  localparam int NV = 6;
  localparam logic [127:0] VEC [NV] = '{
    {16{8'hFF}},                                  // R4 all full scale
    {16{8'h00}},                                  // R5 all zero
    {16{8'h80}},                                  // R3 all equal
    128'h100F0E0D0C0B0A09_0807060504030201,       // R6 sixteen distinct
    128'h0515253545556575_8595A5B5C5D5E5F5,       // R3 descending
    128'h00FF10FF80103080_01FE00017F7F2000        // R2 R4 R5 mixed repeats
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R4";
      1: return "R5";
      2: return "R3";
      3: return "R6";
      4: return "R3";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ok;
    int base;
    for (int a = 0; a < 51; a++) mem[a] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk({busy, done, wr_en} == 3'b000, "R8 reset", {29'd0, busy, done, wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // Vector walk: each pattern built for a plane with the correct display.
    for (int v = 0; v < NV; v++) begin
      int plane = v % 3;
      duty_flat   = VEC[v];
      disp_colour = need_disp(plane);
      base = wr_total;
      pulse_start(plane);
      #1;
      chk(busy == 1'b1, "R8 busy after start", {31'd0, busy}, 1);
      wait_done(ok);
      chk(ok, "R8 done seen", {31'd0, ok}, 1);
      chk(wr_total - base == 17, "R9 write count", wr_total - base, 17);
      compare_plane(VEC[v], plane, vec_tag(v));
      @(negedge clk);
      chk(!done && !busy, "R8 done one cycle", {30'd0, done, busy}, 0);
    end

    // R7: start under the wrong display plane, stall, then release.
    duty_flat   = VEC[5];
    disp_colour = 2'd0;
    base = wr_total;
    pulse_start(0);
    repeat (80) @(negedge clk);
    chk(wr_total == base, "R7 no write while fenced", wr_total - base, 0);
    chk(busy, "R7 busy while stalled", {31'd0, busy}, 1);
    disp_colour = 2'd1;
    wait_done(ok);
    chk(ok, "R7 done after release", {31'd0, ok}, 1);
    compare_plane(VEC[5], 0, "R7");

    // R7: display toggling during a build of blue.
    duty_flat = VEC[4];
    base = wr_total;
    pulse_start(2);
    ok = 1'b0;
    for (int i = 0; i < 4000 && !ok; i++) begin
      @(posedge clk); #1;
      disp_colour = ((i % 5) < 2) ? 2'd0 : 2'd1;
      @(negedge clk);
      if (done) ok = 1'b1;
    end
    chk(ok, "R7 toggle done", {31'd0, ok}, 1);
    chk(wr_total - base == 17, "R7 toggle write count", wr_total - base, 17);
    compare_plane(VEC[4], 2, "R7");

    // R8: plane 3 is ignored.
    base = wr_total;
    pulse_start(3);
    repeat (5) @(negedge clk);
    chk(!busy && wr_total == base, "R8 plane 3 ignored", {31'd0, busy}, 0);

    // R8 and R10: start while busy ignored, duty changes mid-build ignored.
    duty_flat   = VEC[3];
    disp_colour = 2'd2;
    base = wr_total;
    pulse_start(1);
    repeat (3) @(posedge clk);
    duty_flat = VEC[2];
    pulse_start(0);
    duty_flat = VEC[0];
    wait_done(ok);
    chk(ok, "R10 done", {31'd0, ok}, 1);
    chk(wr_total - base == 17, "R8 start while busy ignored", wr_total - base, 17);
    compare_plane(VEC[3], 1, "R10");

    chk(fence_bad == 0, "R7 fence violations", fence_bad, 0);
    chk(order_bad == 0, "R9 order violations", order_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule